// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets synchronous logic use an external asynchronous static RAM of 32768 bytes. A client raises a request with a direction flag, a 15-bit word address and, for stores, a byte of data. The controller accepts it when idle, latches it, and then runs the memory control strobes through a fixed sequence of clock-counted phases. It answers with a one-clock completion pulse, and for loads it also returns the byte it captured.

Every phase length comes from a nanosecond figure. The figure is divided by the clock period, rounded up, and never taken below one clock. The same RTL therefore fits any speed grade of the memory and any system clock. Stores are ended by the write strobe, and the output enable stays inactive for the whole store. The data bus driver is only switched on once the memory has had time to release the pins after the last load. When no access is in progress the chip select is inactive, so the memory drops into its low-power standby.

With the default parameters (5 ns clock, 12 ns access and cycle times, 8 ns strobe width and data setup, 9 ns address-to-end, 5 ns output release), a load takes three clock edges and a store takes four.

Top module: `sram_if_ctrl`

## Requirements
- R1: While rst_ni is low, all three memory strobes (mem_ce_no, mem_we_no, mem_oe_no) are high, mem_dq_oe_o is low and rsp_done_o is low. req_ready_o is high once reset is released.
- R2: Whenever req_ready_o is high (no access in progress), mem_ce_no is high.
- R3: A load accepted on a clock edge drives mem_ce_no and mem_oe_no low and keeps mem_we_no high. rsp_done_o goes high for exactly one cycle, on the third clock edge after acceptance. rsp_rdata_o then holds the memory byte at the latched address.
- R4: A store keeps mem_oe_no high throughout. mem_we_no is low for at least two cycles, and during that time mem_ce_no is low, mem_dq_oe_o is high and mem_dq_o is constant. rsp_done_o pulses on the fourth clock edge after acceptance, and the byte is then in memory.
- R5: mem_dq_oe_o is never high while mem_oe_no is low. After mem_oe_no rises, mem_dq_oe_o stays low for at least one full clock (the ceiling of 5 ns over the clock period).
- R6: During a store, mem_ce_no stays low for at least three cycles (the ceiling of the 12 ns write cycle).
- R7: While mem_ce_no is low, mem_addr_o does not change. Changes on req_addr_i and req_wdata_i after acceptance do not affect the access in progress.
- R8: req_ready_o is low from acceptance until the completion edge. A request presented while req_ready_o is low is dropped and never reaches the memory.
- R9: A new request presented in the cycle after rsp_done_o completes correctly, including a store following a load and a load following a store at the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 15 | Word address |
| req_wdata_i | input | 8 | Store data |
| req_ready_o | output | 1 | Controller idle; request accepted on this edge if valid |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 8 | Captured load data |
| mem_ce_no | output | 1 | Memory chip select, active low |
| mem_we_no | output | 1 | Memory write strobe, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_addr_o | output | 15 | Memory address pins |
| mem_dq_o | output | 8 | Data driven toward memory |
| mem_dq_oe_o | output | 1 | Tri-state enable for mem_dq_o |
| mem_dq_i | input | 8 | Data returned by memory |

## Verification
A phase counter loaded with the wrong value changes when rsp_done_o arrives and how long the write strobe stays low. Both are visible at the pins within the access where the fault occurs. A wrong state decode most likely turns on the bus driver while the output enable is still low, or ends a store without a driven bus. These are cycle-level pin relations, and a bus model sees them at once. A latch fault on the request shows up at the latest on the next load of the affected address, as wrong data or as a store that landed at the wrong place.

// File: rtl/sram_if_pkg.sv
package sram_if_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER
  } ctrl_state_e;

  // ceiling division, never below one clock
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic is_write_state(input ctrl_state_e s);
    return (s == ST_WR_SETUP) || (s == ST_WR_PULSE) || (s == ST_WR_RECOVER);
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_bus_guard.sv
// Counts clocks since output enable was released; bus may be driven once done.
module sram_bus_guard #(
  parameter int unsigned HZ_CYC = 1,
  localparam int unsigned GW    = (HZ_CYC < 2) ? 1 : $clog2(HZ_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_release_i,
  output logic clear_o
);

  logic [GW-1:0] gcnt_q, gcnt_d;

  always_comb begin
    if (oe_release_i) begin
      gcnt_d = GW'(HZ_CYC);
    end else if (gcnt_q != '0) begin
      gcnt_d = gcnt_q - 1'b1;
    end else begin
      gcnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gcnt_q <= '0;
    else         gcnt_q <= gcnt_d;
  end

  // clear refers to the value after this edge
  assign clear_o = (gcnt_d == '0);

endmodule

// File: rtl/sram_if_ctrl.sv
module sram_if_ctrl
  import sram_if_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned T_RC_NS       = 12,
  parameter int unsigned T_AA_NS       = 12,
  parameter int unsigned T_DOE_NS      = 5,
  parameter int unsigned T_HZOE_NS     = 5,
  parameter int unsigned T_SA_NS       = 0,
  parameter int unsigned T_PWE_NS      = 8,
  parameter int unsigned T_SD_NS       = 8,
  parameter int unsigned T_AW_NS       = 9,
  parameter int unsigned T_WC_NS       = 12,
  parameter int unsigned T_HD_NS       = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned RD_CYC  = max_u(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                    max_u(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                          ns_to_cyc(T_DOE_NS, CLK_PERIOD_NS)));
  localparam int unsigned HZ_CYC  = ns_to_cyc(T_HZOE_NS, CLK_PERIOD_NS);
  localparam int unsigned SU_CYC  = ns_to_cyc(T_SA_NS, CLK_PERIOD_NS);
  localparam int unsigned PW_CYC  = max_u(ns_to_cyc(T_PWE_NS, CLK_PERIOD_NS),
                                    max_u(ns_to_cyc(T_SD_NS, CLK_PERIOD_NS),
                                          ns_to_cyc(T_AW_NS, CLK_PERIOD_NS)));
  localparam int unsigned WC_CYC  = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int unsigned REC_CYC = max_u(ns_to_cyc(T_HD_NS, CLK_PERIOD_NS),
                                    (WC_CYC > SU_CYC + PW_CYC) ? WC_CYC - SU_CYC - PW_CYC : 1);
  localparam int unsigned MAX_CYC = max_u(max_u(RD_CYC, SU_CYC), max_u(PW_CYC, REC_CYC));
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  ctrl_state_e state_q, state_d;
  logic             accept;
  logic             cnt_load, cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  logic             oe_release, bus_clear;

  logic              ce_n_q, we_n_q, oe_n_q, dq_oe_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  assign accept = req_valid_i && (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          cnt_load = 1'b1;
          if (req_write_i) begin
            state_d = ST_WR_SETUP;
            cnt_val = CNT_W'(SU_CYC - 1);
          end else begin
            state_d = ST_RD_WAIT;
            cnt_val = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_RD_WAIT: begin
        if (cnt_zero) state_d = ST_IDLE;
      end
      ST_WR_SETUP: begin
        // strobe only once the bus has actually been driven
        if (cnt_zero && dq_oe_q) begin
          state_d  = ST_WR_PULSE;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(PW_CYC - 1);
        end
      end
      ST_WR_PULSE: begin
        if (cnt_zero) begin
          state_d  = ST_WR_RECOVER;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(REC_CYC - 1);
        end
      end
      ST_WR_RECOVER: begin
        if (cnt_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  sram_phase_cnt #(
    .CNT_W (CNT_W)
  ) i_phase_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .zero_o     (cnt_zero)
  );

  assign oe_release = (state_q == ST_RD_WAIT) && (state_d != ST_RD_WAIT);

  sram_bus_guard #(
    .HZ_CYC (HZ_CYC)
  ) i_bus_guard (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .oe_release_i (oe_release),
    .clear_o      (bus_clear)
  );

  // state and pins registered together so the strobes are glitch free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_q  <= (state_d == ST_IDLE);
      we_n_q  <= (state_d != ST_WR_PULSE);
      oe_n_q  <= (state_d != ST_RD_WAIT);
      dq_oe_q <= is_write_state(state_d) && bus_clear;
      done_q  <= cnt_zero && ((state_q == ST_RD_WAIT) || (state_q == ST_WR_RECOVER));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if ((state_q == ST_RD_WAIT) && cnt_zero) rdata_q <= mem_dq_i;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_done_o  = done_q;
  assign rsp_rdata_o = rdata_q;
  assign mem_ce_no   = ce_n_q;
  assign mem_we_no   = we_n_q;
  assign mem_oe_no   = oe_n_q;
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = dq_oe_q;

endmodule

// File: rtl/sram_if_ctrl_chk.sv
module sram_if_ctrl_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_done_o,
  input logic              mem_ce_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_dq_oe_o
);

  p_idle_deselect_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> mem_ce_no);

  p_done_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);

  p_store_pins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_oe_no && !mem_ce_no && mem_dq_oe_o));

  p_no_contention_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_no));

  p_turnaround_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> $past(mem_oe_no));

  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && !$past(mem_ce_no)) |-> $stable(mem_addr_o));

endmodule

bind sram_if_ctrl sram_if_ctrl_chk #(
  .ADDR_W (ADDR_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_done_o  (rsp_done_o),
  .mem_ce_no   (mem_ce_no),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_addr_o  (mem_addr_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/test_sram_if_ctrl.sv
`timescale 1ns/100ps
module test_sram_if_ctrl;

  localparam real CLK_NS   = 5.0;
  localparam int  RD_EDGES = 3;  // ceil(12/5)
  localparam int  WR_EDGES = 4;  // 1 setup + ceil(9/5) strobe + 1 recover
  localparam int  PW_MIN   = 2;  // ceil(8/5)
  localparam int  WC_MIN   = 3;  // ceil(12/5)
  localparam int  HZ_MIN   = 1;  // ceil(5/5)

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [14:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic        req_ready_o, rsp_done_o;
  logic [7:0]  rsp_rdata_o;
  logic        mem_ce_no, mem_we_no, mem_oe_no, mem_dq_oe_o;
  logic [14:0] mem_addr_o;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = '0;

  int checks = 0;
  int failures = 0;

  sram_if_ctrl i_sram_if_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i,
    .req_ready_o, .rsp_done_o, .rsp_rdata_o, .mem_ce_no, .mem_we_no, .mem_oe_no,
    .mem_addr_o, .mem_dq_o, .mem_dq_oe_o, .mem_dq_i
  );

  always #(CLK_NS / 2.0) clk_i = ~clk_i;

  // ---------------- memory model and pin monitors ----------------
  logic [7:0] mem [int];
  int v_idle = 0, v_wr = 0, v_cont = 0, v_turn = 0, v_wc = 0, v_addr = 0;
  logic p_ce = 1'b1, p_we = 1'b1, p_oe = 1'b1, p_dq_oe = 1'b0;
  logic [14:0] p_addr = '0;
  logic [7:0]  wd = '0;
  int we_run = 0, ce_run = 0, oe_hi_run = 1000;
  bit saw_we = 0;

  function automatic logic [7:0] peek(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (req_ready_o && !mem_ce_no) v_idle++;
      if (mem_dq_oe_o && !mem_oe_no) v_cont++;
      if (mem_oe_no) oe_hi_run = (oe_hi_run < 1000) ? oe_hi_run + 1 : 1000;
      else           oe_hi_run = 0;
      if (mem_dq_oe_o && !p_dq_oe && oe_hi_run <= HZ_MIN) v_turn++;
      if (!mem_we_no) begin
        if (!mem_oe_no || mem_ce_no || !mem_dq_oe_o) v_wr++;
        if (p_we) wd = mem_dq_o;
        else if (mem_dq_o != wd) v_wr++;
        we_run++;
      end else if (!p_we) begin
        if (we_run < PW_MIN) v_wr++;
        mem[int'(p_addr)] = wd;
        we_run = 0;
      end
      if (!mem_ce_no) begin
        ce_run++;
        if (!mem_we_no) saw_we = 1;
        if (!p_ce && mem_addr_o != p_addr) v_addr++;
      end else if (!p_ce) begin
        if (saw_we && ce_run < WC_MIN) v_wc++;
        ce_run = 0;
        saw_we = 0;
      end
      mem_dq_i <= (!mem_ce_no && !mem_oe_no && mem_we_no) ? peek(int'(mem_addr_o)) : 8'hE7;
    end
    p_ce = mem_ce_no; p_we = mem_we_no; p_oe = mem_oe_no;
    p_dq_oe = mem_dq_oe_o; p_addr = mem_addr_o;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // mode: 0 plain, 1 scramble inputs after accept, 2 intrude while busy
  task automatic do_write(input logic [14:0] a, input logic [7:0] d, input int mode);
    int cyc = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    @(posedge clk_i);
    forever begin
      @(negedge clk_i);
      cyc++;
      if (mode == 2 && cyc <= 2) begin
        req_valid_i = 1'b1; req_write_i = 1'b1;
        req_addr_i = a + 15'd1; req_wdata_i = 8'h99;
        if (cyc == 1) check(!req_ready_o, "R8", "ready while busy", req_ready_o, 0);
      end else if (mode == 1) begin
        req_valid_i = 1'b0; req_addr_i = a ^ 15'h0300; req_wdata_i = ~d;
      end else begin
        req_valid_i = 1'b0;
      end
      if (rsp_done_o || cyc > 40) break;
    end
    req_valid_i = 1'b0;
    check(cyc == WR_EDGES + 1, "R4", "store latency", cyc, WR_EDGES + 1);
  endtask

  task automatic do_read(input logic [14:0] a, input logic [7:0] exp, input string req);
    int cyc = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a;
    @(posedge clk_i);
    forever begin
      @(negedge clk_i);
      req_valid_i = 1'b0;
      cyc++;
      if (cyc == 1)
        check(!mem_ce_no && !mem_oe_no && mem_we_no, "R3", "load strobes",
              {mem_ce_no, mem_oe_no, mem_we_no}, 3'b001);
      if (rsp_done_o || cyc > 40) break;
    end
    check(cyc == RD_EDGES + 1, "R3", "load latency", cyc, RD_EDGES + 1);
    check(rsp_rdata_o == exp, req, "load data", rsp_rdata_o, exp);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    check(mem_ce_no && mem_we_no && mem_oe_no, "R1", "strobes in reset",
          {mem_ce_no, mem_we_no, mem_oe_no}, 3'b111);
    check(!mem_dq_oe_o && !rsp_done_o, "R1", "bus/done in reset",
          {mem_dq_oe_o, rsp_done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(req_ready_o && mem_ce_no, "R1", "ready after reset",
          {req_ready_o, mem_ce_no}, 2'b11);
  endtask

  task automatic t_basic();
    do_write(15'h1234, 8'h5A, 0);
    do_read(15'h1234, 8'h5A, "R3");
    @(negedge clk_i);
    check(!rsp_done_o, "R3", "done single cycle", rsp_done_o, 0);
  endtask

  task automatic t_patterns();
    do_write(15'h0000, 8'h00, 0);
    do_write(15'h7FFF, 8'hFF, 0);
    do_write(15'h2AAA, 8'h55, 0);
    do_write(15'h5555, 8'hAA, 0);
    do_read(15'h7FFF, 8'hFF, "R3");
    do_read(15'h0000, 8'h00, "R3");
    do_read(15'h5555, 8'hAA, "R3");
    do_read(15'h2AAA, 8'h55, "R3");
  endtask

  task automatic t_latch();
    do_write(15'h0100, 8'hC3, 1);
    do_read(15'h0100, 8'hC3, "R7");
    do_read(15'h0200, 8'h00, "R7");
  endtask

  task automatic t_busy();
    do_write(15'h0300, 8'h11, 2);
    do_read(15'h0301, 8'h00, "R8");
    do_read(15'h0300, 8'h11, "R8");
  endtask

  task automatic t_back_to_back();
    do_write(15'h0400, 8'h77, 0);
    do_read(15'h0400, 8'h77, "R9");
    do_write(15'h0400, 8'h88, 0);
    do_read(15'h0400, 8'h88, "R9");
  endtask

  task automatic t_monitors();
    check(v_idle == 0, "R2", "select while idle", v_idle, 0);
    check(v_wr == 0, "R4", "store strobe faults", v_wr, 0);
    check(v_cont == 0, "R5", "bus contention", v_cont, 0);
    check(v_turn == 0, "R5", "turnaround gap", v_turn, 0);
    check(v_wc == 0, "R6", "short store cycle", v_wc, 0);
    check(v_addr == 0, "R7", "address moved", v_addr, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_patterns();
    t_latch();
    t_busy();
    t_back_to_back();
    repeat (2) @(negedge clk_i);
    t_monitors();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule